// File: doc/BRIEF.md
# Serial-to-Parallel Word Assembler

This block rebuilds a parallel word from a serial bit stream that delivers one bit per sample interval. A qualifying strobe marks each cycle that carries a valid bit. An internal position counter selects one output of a 1-to-N data distributor, and the distributor steers the incoming bit to that position's own storage flip-flop. Bits are written in place at the addressed position rather than shifted along a chain. Positions that are not selected keep their contents.

When the last position of a word is filled, the completed word is copied into a holding register and a one-cycle ready flag is raised. The word therefore stays readable and stable while the next word fills. The word width is a parameter, and its minimum is 2. Recovering the line clock, detecting start bits and framing words from the line itself are left to the surrounding logic.

Top module: `serial_word_assembler`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the next word position becomes 0, `par_word` becomes all zeros and `word_ready` becomes 0.
- R2: In a cycle where `bit_strobe` is low, `ser_bit` is ignored. No position is written, the position counter holds, and `par_word` and `word_ready` do not change. Idle cycles between the valid bits of a word leave the assembled word unaltered.
- R3: Valid bits after a word boundary fill positions 0, 1, ..., WIDTH-1 in order. Bit k of `par_word` is the k-th valid bit of the word, counting the first as bit 0.
- R4: After position WIDTH-1 is filled, the position counter wraps to 0. The next valid bit starts a new word at bit 0, with no idle cycle needed between words.
- R5: `word_ready` is 1 for exactly one clock cycle: the cycle that follows the rising edge that captured bit WIDTH-1. It is 0 at all other times.
- R6: `par_word` changes only at the edge that raises `word_ready`. While the next word fills, it keeps the last completed word.
- R7: A synchronous reset in the middle of a word discards the partial word. The next valid bit after reset is placed at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_strobe | input | 1 | High in cycles where `ser_bit` carries a valid bit |
| ser_bit | input | 1 | Serial data input |
| par_word | output | WIDTH | Last completed parallel word |
| word_ready | output | 1 | One-cycle pulse when `par_word` has just been updated |

## Verification
A position counter that is stuck, skips a value or fails to wrap shows at the ports within one word. `word_ready` then arrives early, arrives late or never arrives, and the bits in `par_word` come out rotated or duplicated. A distributor that writes an unselected position, or that ignores the strobe, corrupts the word that is loaded at the next boundary. A holding register that loads at the wrong time shows as `par_word` changing while `word_ready` is low, and that can be seen within the cycle in which it happens.

// File: rtl/s2p_pkg.sv
`timescale 1ns/1ps
package s2p_pkg;

  // Position that follows cur in a word of the given width (wraps to 0).
  function automatic int slot_after(int cur, int width);
    return (cur >= width - 1) ? 0 : cur + 1;
  endfunction

  // True when cur is the last position of a word.
  function automatic bit slot_is_last(int cur, int width);
    return cur == width - 1;
  endfunction

endpackage

// File: rtl/s2p_slot_ctr.sv
`timescale 1ns/1ps
module s2p_slot_ctr #(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] slot_o,
  output logic          wrap_o
);
  import s2p_pkg::*;

  logic [IW-1:0] slot_q;
  logic [IW-1:0] slot_step;

  assign slot_step = IW'(slot_after(32'(slot_q), WIDTH));
  assign wrap_o    = adv && slot_is_last(32'(slot_q), WIDTH);
  assign slot_o    = slot_q;

  always_ff @(posedge clk) begin
    if (rst)      slot_q <= '0;
    else if (adv) slot_q <= slot_step;
  end

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(slot_o));
  // R4
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (slot_o == '0));
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(slot_o) < WIDTH);

endmodule

// File: rtl/s2p_bit_steer.sv
`timescale 1ns/1ps
module s2p_bit_steer #(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [IW-1:0]    sel,
  input  logic             din,
  output logic [WIDTH-1:0] cell_q,
  output logic [WIDTH-1:0] cell_nxt
);

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    logic hit;
    assign hit         = adv && (sel == IW'(j));
    assign cell_nxt[j] = hit ? din : cell_q[j];

    always_ff @(posedge clk) begin
      if (rst) cell_q[j] <= 1'b0;
      else     cell_q[j] <= cell_nxt[j];
    end

    // R2
    cell_keep_chk: assert property (@(posedge clk) disable iff (rst)
      !(adv && (sel == IW'(j))) |=> $stable(cell_q[j]));
    // R3
    cell_take_chk: assert property (@(posedge clk) disable iff (rst)
      (adv && (sel == IW'(j))) |=> (cell_q[j] == $past(din)));
  end

endmodule

// File: rtl/s2p_word_hold.sv
`timescale 1ns/1ps
module s2p_word_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out,
  output logic             rdy
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      rdy      <= 1'b0;
    end else begin
      rdy <= load;
      if (load) word_out <= word_in;
    end
  end

  // R5
  rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);

endmodule

// File: rtl/serial_word_assembler.sv
`timescale 1ns/1ps
module serial_word_assembler #(
  parameter int WIDTH = 8,
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_strobe,
  input  logic             ser_bit,
  output logic [WIDTH-1:0] par_word,
  output logic             word_ready
);

  // Named internal events
  logic [IW-1:0]    cur_slot;
  logic             word_done;
  logic [WIDTH-1:0] cells;
  logic [WIDTH-1:0] cells_next;

  s2p_slot_ctr #(.WIDTH(WIDTH)) ctr_i (
    .clk    (clk),
    .rst    (rst),
    .adv    (bit_strobe),
    .slot_o (cur_slot),
    .wrap_o (word_done)
  );

  s2p_bit_steer #(.WIDTH(WIDTH)) steer_i (
    .clk      (clk),
    .rst      (rst),
    .adv      (bit_strobe),
    .sel      (cur_slot),
    .din      (ser_bit),
    .cell_q   (cells),
    .cell_nxt (cells_next)
  );

  s2p_word_hold #(.WIDTH(WIDTH)) hold_i (
    .clk      (clk),
    .rst      (rst),
    .load     (word_done),
    .word_in  (cells_next),
    .word_out (par_word),
    .rdy      (word_ready)
  );

  initial begin
    // R3
    width_min_chk: assert (WIDTH >= 2);
  end

  // R6
  word_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !word_done |=> $stable(par_word));
  // R5
  ready_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> word_ready);
  // R2
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_strobe |=> !word_ready);

endmodule

// File: tb/serial_word_assembler_tb_top.sv
`timescale 1ns/1ps
module serial_word_assembler_tb_top;
  localparam int W = 8;
  localparam int NV = 8;
  // Each entry: {idle-before-bit mask[15:8], word[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    16'h00A5, 16'h003C, 16'h81FF, 16'h0000,
    16'h5596, 16'h0001, 16'hFF80, 16'h107E
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_strobe = 1'b0;
  logic ser_bit = 1'b0;
  logic [W-1:0] par_word;
  logic word_ready;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serial_word_assembler #(.WIDTH(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bit_strobe (bit_strobe),
    .ser_bit    (ser_bit),
    .par_word   (par_word),
    .word_ready (word_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply inputs, let one rising edge pass, then settle mid-cycle.
  task automatic drive(input logic v, input logic d);
    bit_strobe = v;
    ser_bit = d;
    @(posedge clk);
    #5;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    logic [W-1:0] word;
    logic [7:0] gap;

    // R1: reset state
    rst = 1'b1;
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    check(par_word == '0, "R1 par_word after reset", 32'(par_word), 0);
    check(word_ready == 1'b0, "R1 word_ready after reset", 32'(word_ready), 0);
    rst = 1'b0;

    prev = '0;
    for (int v = 0; v < NV; v++) begin
      word = VEC[v][7:0];
      gap = VEC[v][15:8];
      for (int k = 0; k < W; k++) begin
        if (gap[k]) begin
          drive(1'b0, ~word[k]);
          check(word_ready == 1'b0, "R2 idle raises no ready", 32'(word_ready), 0);
          check(par_word == prev, "R2 idle leaves word", 32'(par_word), 32'(prev));
        end
        drive(1'b1, word[k]);
        if (k < W - 1) begin
          check(word_ready == 1'b0, "R5 no ready mid-word", 32'(word_ready), 0);
          check(par_word == prev, "R6 held while filling", 32'(par_word), 32'(prev));
        end else begin
          check(word_ready == 1'b1, "R5 ready after last bit", 32'(word_ready), 1);
          check(par_word == word, "R3 R4 assembled word", 32'(par_word), 32'(word));
        end
      end
      drive(1'b0, 1'b1);
      check(word_ready == 1'b0, "R5 ready one cycle", 32'(word_ready), 0);
      check(par_word == word, "R6 word kept", 32'(par_word), 32'(word));
      prev = word;
    end

    // R2: long idle stretch with toggling data
    for (int i = 0; i < 6; i++) drive(1'b0, i[0]);
    check(par_word == prev && !word_ready, "R2 long idle", 32'(par_word), 32'(prev));

    // R7: reset part-way through a word
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b1);
    rst = 1'b1;
    drive(1'b0, 1'b0);
    rst = 1'b0;
    check(par_word == '0, "R7 R1 word cleared", 32'(par_word), 0);
    check(word_ready == 1'b0, "R7 R1 ready cleared", 32'(word_ready), 0);
    word = 8'hC3;
    for (int k = 0; k < W; k++) begin
      drive(1'b1, word[k]);
      if (k < W - 1)
        check(word_ready == 1'b0, "R7 no early ready", 32'(word_ready), 0);
    end
    check(word_ready == 1'b1, "R7 ready after full word", 32'(word_ready), 1);
    check(par_word == word, "R7 word starts at bit 0", 32'(par_word), 32'(word));

    report();
    $finish;
  end
endmodule